// File: doc/BRIEF.md
# Four-Core Boot and Reset Control Registers

This block is a memory-mapped register file that starts, stops and resets the cores of a four-core cluster. Software reaches it over a simple 32-bit register bus. Reads are combinational and complete in the cycle of the strobe. Writes take effect at the next rising clock edge. The 4 KiB window holds a control word, a status word, an interrupt-mask word, an interrupt-status word and six general-purpose words. Those six words carry an entry address and an argument for each of cores 1, 2 and 3.

When software writes the control word, the block compares the new value with the stored one, and only the bits that differ cause an action. A changed core-enable bit produces a one-cycle power-on or power-off request toward that core. A changed core-reset bit produces a one-cycle reset pulse. The stored core-reset bit then stays set until the core pulses its completion input. The two display-unit reset bits read back as zero at all times. Cores whose presence input is low receive no requests.

Top module: `core_boot_reset`

## Requirements
- R1: After reset, word 0 (control) reads 0x00000521, word 1 (status) reads 0x00000001, word 2 (mask) reads 0x0000001F, and every other word reads 0. All request and pulse outputs are low.
- R2: The word index is address bits [11:2]. An access with address bits [1:0] not equal to zero is rejected. A rejected read returns 0 with `regErr` high, and a rejected write changes nothing.
- R3: Word indices 10 and above are unimplemented. A read there returns 0 with `regErr` high, and a write there changes no register.
- R4: Words 1 to 9 store and return the full 32-bit written value. Words 4/5, 6/7 and 8/9 are the entry/argument pairs of cores 1, 2 and 3.
- R5: A control write whose value equals the stored value produces no request and no pulse.
- R6: When the enable bit of core n (bit 21+n, n = 1..3) changes from 0 to 1, `onReq[n]` is high for one cycle, starting at the clock edge that stores the write. In that cycle, `entryAddr[32n+31:32n]` and `entryArg[32n+31:32n]` carry that core's entry/argument pair.
- R7: When an enable bit changes from 1 to 0, `offReq[n]` is high for one cycle. The request is never raised together with `onReq[n]`.
- R8: An enable change makes the stored reset bit of that core (bit 13+n) pending. No reset pulse is issued for that core in the same write, even if its reset bit also changed. The stored reset bit clears on the core's completion pulse.
- R9: A change of the reset bit of core n (bit 13+n, n = 0..3) gives `rstPulse[n]` high for one cycle. The stored bit keeps its written value until `coreDone[n]` pulses. A completion pulse for another core leaves it unchanged.
- R10: Control bits 3 and 12 (display-unit resets) always read as 0, whatever is written.
- R11: A core whose `corePresent` bit is low gets no request or pulse, and nothing becomes pending for it. Its written bits stay stored, and its completion pulse has no effect.
- R12: A single control write that changes bits of several cores raises the requests and pulses of all of those cores in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regAddr | input | 12 | Byte address within the window |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the cycle of the strobe |
| regErr | output | 1 | Access rejected (misaligned or unimplemented word) |
| corePresent | input | 4 | Per-core presence, one bit per core |
| coreDone | input | 4 | Per-core completion pulse |
| onReq | output | 4 | Per-core power-on request, one cycle |
| offReq | output | 4 | Per-core power-off request, one cycle |
| rstPulse | output | 4 | Per-core reset pulse, one cycle |
| entryAddr | output | 128 | Entry address per core, 32 bits each, core 0 slice zero |
| entryArg | output | 128 | Entry argument per core, 32 bits each, core 0 slice zero |

## Verification
The hardest state to reach from the ports is a stored reset bit that is held while its completion is outstanding. Reaching it needs a control write that moves a reset bit and an enable bit of one core together, followed by completion pulses that first go to the wrong core and then to the right one. Only then does readback show whether the hold and the release are tied to the correct core. The bench builds this sequence on purpose. It also drops one core's presence input so that a written reset bit is left stranded with nothing pending, and confirms that a completion pulse for that core has no effect.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int NCORE   = 4;
  localparam int DW      = 32;
  localparam int AW      = 12;
  localparam int IDXW    = AW - 2;
  localparam int NGP     = 2 * (NCORE - 1);
  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_MASK = 2;
  localparam int IDX_GP0  = 4;
  localparam int NREG    = IDX_GP0 + NGP;
  // control word bit positions
  localparam int RST_LSB = 13;
  localparam int EN_LSB  = 21;
  localparam int DISP_A  = 3;
  localparam int DISP_B  = 12;
  localparam logic [DW-1:0] DISP_MASK = (DW'(1) << DISP_A) | (DW'(1) << DISP_B);
  localparam logic [DW-1:0] CTRL_INIT = 32'h0000_0521;
  localparam logic [DW-1:0] STAT_INIT = 32'h0000_0001;
  localparam logic [DW-1:0] MASK_INIT = 32'h0000_001F;

  typedef struct packed {
    logic            wrEn;
    logic            rdEn;
    logic [IDXW-1:0] idx;
    logic [NCORE-1:0] rstClr;
  } strobe_t;
endpackage

// File: rtl/cbr_regs.sv
module cbr_regs
  import cbr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic [DW-1:0]       ctrlQ,
  output logic [NCORE*DW-1:0] entryAddr,
  output logic [NCORE*DW-1:0] entryArg
);
  logic [DW-1:0] regQ [NREG];
  logic [DW-1:0] ctrlNext;
  logic          ctrlWr;

  function automatic logic [DW-1:0] initVal(int i);
    case (i)
      IDX_CTRL: return CTRL_INIT;
      IDX_STAT: return STAT_INIT;
      IDX_MASK: return MASK_INIT;
      default:  return '0;
    endcase
  endfunction

  assign ctrlWr = stb.wrEn && (stb.idx == IDXW'(IDX_CTRL));

  // new control value: written value without display resets, then completion clears
  always_comb begin
    ctrlNext = regQ[IDX_CTRL];
    if (ctrlWr) ctrlNext = wdata & ~DISP_MASK;
    ctrlNext = ctrlNext & ~(DW'(stb.rstClr) << RST_LSB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regQ[i] <= initVal(i);
    end else begin
      regQ[IDX_CTRL] <= ctrlNext;
      for (int i = 1; i < NREG; i++)
        if (stb.wrEn && stb.idx == IDXW'(i)) regQ[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (stb.rdEn && stb.idx == IDXW'(i)) rdata = regQ[i];
  end

  assign ctrlQ = regQ[IDX_CTRL];

  genvar n;
  generate
    for (n = 0; n < NCORE; n++) begin : g_entry
      if (n == 0) begin : g_none
        assign entryAddr[n*DW +: DW] = '0;
        assign entryArg[n*DW +: DW]  = '0;
      end else begin : g_pair
        assign entryAddr[n*DW +: DW] = regQ[IDX_GP0 + 2*(n-1)];
        assign entryArg[n*DW +: DW]  = regQ[IDX_GP0 + 2*(n-1) + 1];
      end

      // R9: a stored reset bit only drops on a write or a completion strobe
      assert_rst_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
        $fell(regQ[IDX_CTRL][RST_LSB+n]) |-> ($past(stb.rstClr[n]) || $past(ctrlWr)));
    end
  endgenerate

  assert_disp_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regQ[IDX_CTRL][DISP_A] == 1'b0) && (regQ[IDX_CTRL][DISP_B] == 1'b0));

  assert_gp_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrEn && stb.idx == IDXW'(IDX_GP0)) |=> $stable(regQ[IDX_GP0]));
endmodule

// File: rtl/cbr_ctl.sv
module cbr_ctl
  import cbr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regRd,
  input  logic             regWr,
  input  logic [AW-1:0]    regAddr,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    ctrlQ,
  input  logic [NCORE-1:0] corePresent,
  input  logic [NCORE-1:0] coreDone,
  output strobe_t          stb,
  output logic             regErr,
  output logic [NCORE-1:0] onReq,
  output logic [NCORE-1:0] offReq,
  output logic [NCORE-1:0] rstPulse
);
  logic            aligned, inRange, accOk, ctrlWr;
  logic [IDXW-1:0] idx;
  logic [DW-1:0]   change;
  logic [NCORE-1:0] enChg, rstChg, enNew, act, pendQ;

  assign idx     = regAddr[AW-1:2];
  assign aligned = (regAddr[1:0] == 2'b00);
  assign inRange = (idx < IDXW'(NREG));
  assign accOk   = aligned && inRange;
  assign regErr  = (regRd || regWr) && !accOk;
  assign ctrlWr  = regWr && accOk && (idx == IDXW'(IDX_CTRL));
  assign change  = ctrlQ ^ wdata;

  genvar n;
  generate
    for (n = 0; n < NCORE; n++) begin : g_core
      if (n == 0) begin : g_noen
        assign enChg[n] = 1'b0;
        assign enNew[n] = 1'b0;
      end else begin : g_en
        assign enChg[n] = change[EN_LSB+n];
        assign enNew[n] = wdata[EN_LSB+n];
      end
      // an enable change owns the reset bit: no separate pulse
      assign rstChg[n] = change[RST_LSB+n] && !enChg[n];

      assert_pend_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
        $fell(pendQ[n]) |-> $past(coreDone[n]));
    end
  endgenerate

  assign act = {NCORE{ctrlWr}} & corePresent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onReq    <= '0;
      offReq   <= '0;
      rstPulse <= '0;
      pendQ    <= '0;
    end else begin
      onReq    <= act & enChg & enNew;
      offReq   <= act & enChg & ~enNew;
      rstPulse <= act & rstChg;
      pendQ    <= (pendQ & ~coreDone) | (act & (enChg | rstChg));
    end
  end

  always_comb begin
    stb.wrEn   = regWr && accOk;
    stb.rdEn   = regRd && accOk;
    stb.idx    = idx;
    stb.rstClr = coreDone & pendQ;
  end

  assert_on_off_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    (onReq & offReq) == '0);

  assert_absent_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((onReq | offReq | rstPulse) & ~$past(corePresent)) == '0);

  assert_no_rst_on_en_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((onReq | offReq) & rstPulse) == '0);
endmodule

// File: rtl/core_boot_reset.sv
module core_boot_reset
  import cbr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regRd,
  input  logic                regWr,
  input  logic [AW-1:0]       regAddr,
  input  logic [DW-1:0]       regWdata,
  output logic [DW-1:0]       regRdata,
  output logic                regErr,
  input  logic [NCORE-1:0]    corePresent,
  input  logic [NCORE-1:0]    coreDone,
  output logic [NCORE-1:0]    onReq,
  output logic [NCORE-1:0]    offReq,
  output logic [NCORE-1:0]    rstPulse,
  output logic [NCORE*DW-1:0] entryAddr,
  output logic [NCORE*DW-1:0] entryArg
);
  strobe_t       stb;
  logic [DW-1:0] ctrlQ;

  cbr_ctl u_ctl (
    .clk(clk), .rstN(rstN), .regRd(regRd), .regWr(regWr), .regAddr(regAddr),
    .wdata(regWdata), .ctrlQ(ctrlQ), .corePresent(corePresent), .coreDone(coreDone),
    .stb(stb), .regErr(regErr), .onReq(onReq), .offReq(offReq), .rstPulse(rstPulse)
  );

  cbr_regs u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(regWdata), .rdata(regRdata),
    .ctrlQ(ctrlQ), .entryAddr(entryAddr), .entryArg(entryArg)
  );

  assert_err_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regErr && regRd) |-> (regRdata == '0));
endmodule

// File: tb/sim_core_boot_reset.sv
`timescale 1ns/1ps
module sim_core_boot_reset;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regRd = 1'b0, regWr = 1'b0;
  logic [11:0]  regAddr = '0;
  logic [31:0]  regWdata = '0;
  logic [31:0]  regRdata;
  logic         regErr;
  logic [3:0]   corePresent = 4'hF, coreDone = 4'h0;
  logic [3:0]   onReq, offReq, rstPulse;
  logic [127:0] entryAddr, entryArg;

  int tests = 0, fails = 0;
  logic [3:0]  onC, offC, rstC;
  logic [31:0] eaC, egC, rd;
  logic        er;

  always #4 clk = ~clk;

  core_boot_reset u0 (.*);

  // vector: address, write data, expected readback
  localparam logic [75:0] VEC [0:6] = '{
    {12'h004, 32'hDEAD_0001, 32'hDEAD_0001},
    {12'h008, 32'h0000_0003, 32'h0000_0003},
    {12'h00C, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    {12'h010, 32'h1111_0000, 32'h1111_0000},
    {12'h024, 32'h9999_9999, 32'h9999_9999},
    {12'h000, 32'h0000_1529, 32'h0000_0521},
    {12'h000, 32'h0000_0521, 32'h0000_0521}
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    onC = onReq; offC = offReq; rstC = rstPulse;
    eaC = entryAddr[64 +: 32]; egC = entryArg[64 +: 32];
    regWr = 1'b0;
  endtask

  task automatic doRead(input logic [11:0] a);
    @(negedge clk);
    regRd = 1'b1; regAddr = a; #1;
    rd = regRdata; er = regErr;
    regRd = 1'b0;
  endtask

  task automatic doDone(input logic [3:0] m);
    @(negedge clk); coreDone = m;
    @(posedge clk); #1; coreDone = 4'h0;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    doRead(12'h000); check(rd == 32'h521, "R1 ctrl", rd, 32'h521);
    doRead(12'h004); check(rd == 32'h1, "R1 status", rd, 32'h1);
    doRead(12'h008); check(rd == 32'h1F, "R1 mask", rd, 32'h1F);
    doRead(12'h00C); check(rd == 32'h0, "R1 irq", rd, 32'h0);
    doRead(12'h020); check(rd == 32'h0, "R1 gp", rd, 32'h0);
    check({onReq, offReq, rstPulse} == 12'h0, "R1 outputs", {20'h0, onReq, offReq, rstPulse}, 32'h0);

    // R4 R10 table
    for (int i = 0; i < 7; i++) begin
      doWrite(VEC[i][75:64], VEC[i][63:32]);
      doRead(VEC[i][75:64]);
      check(rd == VEC[i][31:0], "R4/R10 vector", rd, VEC[i][31:0]);
    end

    // R2 misaligned
    doWrite(12'h012, 32'hFFFF_FFFF);
    doRead(12'h010); check(rd == 32'h1111_0000, "R2 write dropped", rd, 32'h1111_0000);
    doRead(12'h011); check(rd == 32'h0 && er, "R2 read err", {er, rd[30:0]}, 32'h8000_0000);

    // R3 out of range
    doRead(12'h028); check(rd == 32'h0 && er, "R3 read idx10", {er, rd[30:0]}, 32'h8000_0000);
    doRead(12'hFFC); check(er == 1'b1, "R3 read top", {31'h0, er}, 32'h1);
    doWrite(12'h028, 32'h1234_5678);
    doRead(12'h024); check(rd == 32'h9999_9999, "R3 write dropped", rd, 32'h9999_9999);
    doRead(12'h000); check(rd == 32'h521, "R3 ctrl intact", rd, 32'h521);

    // R6 R8 core 2 enable with its reset bit
    doWrite(12'h018, 32'h8000_2000);
    doWrite(12'h01C, 32'h2222_0002);
    doWrite(12'h000, 32'h0080_8521);
    check(onC == 4'b0100, "R6 onReq", {28'h0, onC}, 32'h4);
    check(eaC == 32'h8000_2000, "R6 entry", eaC, 32'h8000_2000);
    check(egC == 32'h2222_0002, "R6 arg", egC, 32'h2222_0002);
    check(rstC == 4'b0000, "R8 no pulse", {28'h0, rstC}, 32'h0);
    doRead(12'h000); check(rd == 32'h0080_8521, "R8 held", rd, 32'h0080_8521);
    doDone(4'b0100);
    doRead(12'h000); check(rd == 32'h0080_0521, "R8 cleared", rd, 32'h0080_0521);

    // R7 power off
    doWrite(12'h000, 32'h0000_0521);
    check(offC == 4'b0100 && onC == 4'b0, "R7 offReq", {24'h0, onC, offC}, 32'h04);
    doDone(4'b0100);

    // R5 no change
    doWrite(12'h000, 32'h0000_0521);
    check({onC, offC, rstC} == 12'h0, "R5 quiet", {20'h0, onC, offC, rstC}, 32'h0);

    // R9 core 0 reset
    doWrite(12'h000, 32'h0000_2521);
    check(rstC == 4'b0001, "R9 pulse", {28'h0, rstC}, 32'h1);
    doDone(4'b0010);
    doRead(12'h000); check(rd == 32'h0000_2521, "R9 other done", rd, 32'h2521);
    doDone(4'b0001);
    doRead(12'h000); check(rd == 32'h0000_0521, "R9 released", rd, 32'h521);

    // R12 several cores
    doWrite(12'h000, 32'h0140_2521);
    check(onC == 4'b1010, "R12 onReq", {28'h0, onC}, 32'hA);
    check(rstC == 4'b0001, "R12 rstPulse", {28'h0, rstC}, 32'h1);
    doDone(4'b1011);
    doRead(12'h000); check(rd == 32'h0140_0521, "R12 cleared", rd, 32'h0140_0521);

    // R11 absent core
    corePresent = 4'b1011;
    doWrite(12'h000, 32'h0140_8521);
    check({onC, offC, rstC} == 12'h0, "R11 no pulse", {20'h0, onC, offC, rstC}, 32'h0);
    doDone(4'b0100);
    doRead(12'h000); check(rd == 32'h0140_8521, "R11 done ignored", rd, 32'h0140_8521);
    corePresent = 4'hF;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule